// File: doc/BRIEF.md
# Trigger-Switched Multi-Policy Sample Buffer

This block is a 32-slot queue of 24-bit measurement samples whose fill policy is picked by a 3-bit mode field. Depending on the mode it keeps nothing, fills once and then refuses new samples, or keeps running and overwrites its oldest entry. Three modes start in one policy and move to another when an external trigger input is seen high on a clock edge.

A producer offers samples with a one-cycle valid strobe. A consumer reads the oldest stored sample from the head output and pops it with a one-cycle read strobe. Status outputs give the unread count, a full flag, an empty flag, a watermark flag and an overrun flag. An optional stop-at-watermark bit reduces the usable depth to a programmed 5-bit level.

Top module: `sample_fifo_multimode`

## Requirements
- R1: After reset, and with the enable low, the unread count is 0, empty is 1, and full, watermark and overrun are 0.
- R2: Mode code 000 (and the unused codes 101 and 110) keeps the buffer empty: offered samples are not stored and the count stays 0.
- R3: Mode code 001 stores samples until the usable depth is reached. Later samples are dropped, the stored contents and head are unchanged, full is 1 and overrun is set.
- R4: Mode code 010 keeps accepting samples when full by discarding the oldest entry. The count stays at the usable depth, the head moves to the next-oldest sample, and overrun is set.
- R5: The head output always shows the oldest unread sample. A pop removes it, so samples leave in arrival order, and a pop while empty has no effect.
- R6: With stop-at-watermark set, the usable depth equals the watermark level and the watermark flag is 1 while the count is at or above that level. With it clear, the depth is 32 and the watermark flag is 0.
- R7: Mode code 011 behaves as code 010 until a trigger is sampled high, then behaves as code 001 from the next cycle on.
- R8: Mode code 100 keeps the buffer empty until a trigger is sampled high, then behaves as code 010.
- R9: Mode code 111 keeps the buffer empty until a trigger is sampled high, then behaves as code 001.
- R10: A triggered switch is kept until the mode field changes value, and returning to a triggered mode needs a new trigger. The trigger has no effect in modes 000, 001 and 010.
- R11: Overrun clears on a successful pop. Any change of the mode field clears the count, the pointers and overrun in the cycle it is seen.
- R12: While the enable is low the buffer is held cleared and offered samples are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Buffer enable |
| mode_i | input | 3 | Fill policy code |
| wm_level_i | input | 5 | Watermark level |
| stop_at_wm_i | input | 1 | Limit usable depth to the watermark level |
| trig_i | input | 1 | Trigger event, sampled on the clock |
| push_i | input | 1 | Sample valid strobe |
| push_data_i | input | 24 | Sample value |
| pop_i | input | 1 | Read strobe, removes the head sample |
| head_o | output | 24 | Oldest unread sample |
| count_o | output | 6 | Number of unread samples |
| wm_o | output | 1 | Count at or above watermark level (stop-at-watermark set) |
| ovr_o | output | 1 | A sample was dropped or overwritten |
| full_o | output | 1 | Count at usable depth |
| empty_o | output | 1 | No unread samples |

## Verification
Each policy gets a burst of samples that runs past the usable depth, using values that encode the sample's index. The head after the burst then tells stop-when-full (first sample still at head) apart from overwrite (head advanced by the excess) and from bypass (count 0). The three triggered modes are run with samples both before and after a trigger pulse, so a trigger that is ignored, taken too early or forgotten shows up as a wrong count or head. Short bursts against a small watermark, disable pulses and mode rewrites check the reduced depth, the clearing paths and overrun clearing.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   typedef enum logic [1:0] {
      POL_OFF  = 2'd0,
      POL_HALT = 2'd1,
      POL_RING = 2'd2
   } policy_e;

   localparam logic [2:0] MODE_OFF            = 3'b000;
   localparam logic [2:0] MODE_HALT           = 3'b001;
   localparam logic [2:0] MODE_RING           = 3'b010;
   localparam logic [2:0] MODE_RING_THEN_HALT = 3'b011;
   localparam logic [2:0] MODE_OFF_THEN_RING  = 3'b100;
   localparam logic [2:0] MODE_OFF_THEN_HALT  = 3'b111;
endpackage

// File: rtl/sfifo_policy.sv
module sfifo_policy
   import sfifo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic [2:0] mode_i,
   input  logic       trig_i,
   output policy_e    policy_o,
   output logic       restart_o
);
   logic [2:0] mode_q;
   logic       trig_seen_q;
   logic       trig_mode;

   assign restart_o = !en_i || (mode_i != mode_q);
   assign trig_mode = (mode_i == MODE_RING_THEN_HALT) ||
                      (mode_i == MODE_OFF_THEN_RING)  ||
                      (mode_i == MODE_OFF_THEN_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= MODE_OFF;
         trig_seen_q <= 1'b0;
      end else begin
         mode_q <= mode_i;
         if (restart_o)
            trig_seen_q <= 1'b0;
         else if (trig_i && trig_mode)
            trig_seen_q <= 1'b1;
      end
   end

   always_comb begin
      policy_o = POL_OFF;
      if (en_i) begin
         unique case (mode_i)
            MODE_HALT:           policy_o = POL_HALT;
            MODE_RING:           policy_o = POL_RING;
            MODE_RING_THEN_HALT: policy_o = trig_seen_q ? POL_HALT : POL_RING;
            MODE_OFF_THEN_RING:  policy_o = trig_seen_q ? POL_RING : POL_OFF;
            MODE_OFF_THEN_HALT:  policy_o = trig_seen_q ? POL_HALT : POL_OFF;
            default:             policy_o = POL_OFF;
         endcase
      end
   end

   // R10: a taken trigger persists while the mode field is unchanged
   assert_trig_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_seen_q && en_i && mode_i == mode_q) |=> trig_seen_q);
   // R12: disabling forgets the trigger
   assert_off_forgets_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !trig_seen_q);
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int DW    = 24,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_ptr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic [AW-1:0] rd_ptr_i,
   output logic [DW-1:0] rd_data_o
);
   logic [DEPTH-1:0][DW-1:0] slots;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (wr_en_i && wr_ptr_i == AW'(i))
            slot_q <= wr_data_i;
      end
      assign slots[i] = slot_q;
   end

   assign rd_data_o = slots[rd_ptr_i];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
   import sfifo_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  policy_e       policy_i,
   input  logic          restart_i,
   input  logic [AW-1:0] wm_level_i,
   input  logic          stop_at_wm_i,
   input  logic          push_i,
   input  logic          pop_i,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_ptr_o,
   output logic [AW-1:0] rd_ptr_o,
   output logic [CW-1:0] count_o,
   output logic          wm_o,
   output logic          ovr_o,
   output logic          full_o,
   output logic          empty_o
);
   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] count_q, cap, cnt_after;
   logic          ovr_q, do_pop, space, accept, evict, lost, active;

   assign cap       = stop_at_wm_i ? {1'b0, wm_level_i} : CW'(DEPTH);
   assign active    = (policy_i != POL_OFF) && !restart_i;
   assign do_pop    = pop_i && (count_q != '0) && !restart_i;
   assign cnt_after = count_q - CW'(do_pop);
   assign space     = cnt_after < cap;
   assign accept    = push_i && active && space;
   assign evict     = push_i && active && !space && (policy_i == POL_RING) &&
                      !do_pop && (count_q != '0);
   assign lost      = push_i && active && !accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
         ovr_q    <= 1'b0;
      end else if (restart_i) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
         ovr_q    <= 1'b0;
      end else begin
         if (accept || evict) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (do_pop || evict) rd_ptr_q <= rd_ptr_q + 1'b1;
         count_q <= cnt_after + CW'(accept);
         if (lost)        ovr_q <= 1'b1;
         else if (do_pop) ovr_q <= 1'b0;
      end
   end

   assign wr_en_o  = accept || evict;
   assign wr_ptr_o = wr_ptr_q;
   assign rd_ptr_o = rd_ptr_q;
   assign count_o  = count_q;
   assign ovr_o    = ovr_q;
   assign empty_o  = (count_q == '0);
   assign full_o   = (count_q >= cap);
   assign wm_o     = stop_at_wm_i && (count_q >= {1'b0, wm_level_i});

   assert_count_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));
   assert_halt_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == POL_HALT && !restart_i && push_i && !pop_i && count_q == cap)
      |=> ($stable(count_q) && $stable(rd_ptr_q) && ovr_q));
   assert_ring_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == POL_RING && !restart_i && push_i && !pop_i && count_q == cap && cap != '0)
      |=> ($stable(count_q) && rd_ptr_q == $past(rd_ptr_q) + 1'b1 && ovr_q));
   assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0 && pop_i && !push_i) |=> count_q == '0);
   assert_off_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == POL_OFF && count_q == '0) |=> count_q == '0);
   assert_restart_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (count_q == '0 && !ovr_q && rd_ptr_q == '0));
endmodule

// File: rtl/sample_fifo_multimode.sv
module sample_fifo_multimode
   import sfifo_pkg::*;
#(
   parameter int DW    = 24,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic [2:0]    mode_i,
   input  logic [AW-1:0] wm_level_i,
   input  logic          stop_at_wm_i,
   input  logic          trig_i,
   input  logic          push_i,
   input  logic [DW-1:0] push_data_i,
   input  logic          pop_i,
   output logic [DW-1:0] head_o,
   output logic [CW-1:0] count_o,
   output logic          wm_o,
   output logic          ovr_o,
   output logic          full_o,
   output logic          empty_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("DW must be positive");
   end

   policy_e       policy;
   logic          restart, wr_en;
   logic [AW-1:0] wr_ptr, rd_ptr;

   sfifo_policy u_policy (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_i),
      .mode_i    (mode_i),
      .trig_i    (trig_i),
      .policy_o  (policy),
      .restart_o (restart)
   );

   sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .policy_i     (policy),
      .restart_i    (restart),
      .wm_level_i   (wm_level_i),
      .stop_at_wm_i (stop_at_wm_i),
      .push_i       (push_i),
      .pop_i        (pop_i),
      .wr_en_o      (wr_en),
      .wr_ptr_o     (wr_ptr),
      .rd_ptr_o     (rd_ptr),
      .count_o      (count_o),
      .wm_o         (wm_o),
      .ovr_o        (ovr_o),
      .full_o       (full_o),
      .empty_o      (empty_o)
   );

   sfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .wr_en_i   (wr_en),
      .wr_ptr_i  (wr_ptr),
      .wr_data_i (push_data_i),
      .rd_ptr_i  (rd_ptr),
      .rd_data_o (head_o)
   );

   // R12: while disabled nothing is held
   assert_disabled_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> empty_o);
endmodule

// File: tb/sample_fifo_multimode_tb.sv
module sample_fifo_multimode_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [2:0]  mode = 3'b000;
   logic [4:0]  wm = 5'd0;
   logic        stop = 1'b0;
   logic        trig = 1'b0;
   logic        push = 1'b0;
   logic [23:0] din = '0;
   logic        pop = 1'b0;
   logic [23:0] head;
   logic [5:0]  count;
   logic        wm_f, ovr, full, empty;
   int          total = 0;
   int          bad = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   sample_fifo_multimode u_dut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode), .wm_level_i(wm),
      .stop_at_wm_i(stop), .trig_i(trig), .push_i(push), .push_data_i(din),
      .pop_i(pop), .head_o(head), .count_o(count), .wm_o(wm_f), .ovr_o(ovr),
      .full_o(full), .empty_o(empty)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic put(input int d);
      push = 1'b1; din = d[23:0];
      step();
      push = 1'b0;
   endtask

   task automatic put_run(input int base, input int n);
      for (int i = 0; i < n; i++) put(base + i);
   endtask

   task automatic take();
      pop = 1'b1;
      step();
      pop = 1'b0;
   endtask

   task automatic set_mode(input logic [2:0] m);
      mode = m;
      step();
   endtask

   task automatic pulse_trig();
      trig = 1'b1;
      step();
      trig = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset / disabled state
      chk("R1 count", count, 0);
      chk("R1 empty", empty, 1);
      chk("R1 full", full, 0);
      chk("R1 ovr", ovr, 0);
      chk("R1 wm", wm_f, 0);
      en = 1'b1;
      step();

      // R2 bypass codes
      put_run('h010000, 5);
      chk("R2 mode000 count", count, 0);
      chk("R2 mode000 empty", empty, 1);
      set_mode(3'b101);
      put_run('h020000, 3);
      chk("R2 mode101 count", count, 0);
      set_mode(3'b110);
      put_run('h030000, 3);
      chk("R2 mode110 count", count, 0);

      // R3 stop when full
      set_mode(3'b001);
      put_run('h100000, 32);
      chk("R3 count at depth", count, 32);
      chk("R3 full", full, 1);
      chk("R3 no ovr yet", ovr, 0);
      put_run('hAAAAAA, 3);
      chk("R3 count after drop", count, 32);
      chk("R3 ovr", ovr, 1);
      chk("R3 head kept", head, 'h100000);
      // R5 in-order drain, R11 overrun cleared by pop
      for (int i = 0; i < 32; i++) begin
         chk("R5 head order", head, 'h100000 + i);
         take();
         if (i == 0) chk("R11 ovr cleared by pop", ovr, 0);
      end
      chk("R5 empty after drain", empty, 1);
      take();
      chk("R5 pop on empty count", count, 0);

      // R4 ring overwrite
      set_mode(3'b010);
      put_run('h200000, 40);
      chk("R4 count", count, 32);
      chk("R4 ovr", ovr, 1);
      chk("R4 head advanced", head, 'h200008);
      for (int i = 0; i < 32; i++) begin
         chk("R4 ring order", head, 'h200008 + i);
         take();
      end
      chk("R4 drained", count, 0);

      // R6 watermark-limited depth
      stop = 1'b1; wm = 5'd5;
      set_mode(3'b001);
      put_run('h250000, 4);
      chk("R6 below level wm", wm_f, 0);
      chk("R6 below level count", count, 4);
      put('h250004);
      chk("R6 at level wm", wm_f, 1);
      chk("R6 at level full", full, 1);
      put('h25FFFF);
      chk("R6 capped count", count, 5);
      chk("R6 capped ovr", ovr, 1);
      chk("R6 capped head", head, 'h250000);
      stop = 1'b0;
      step();
      chk("R6 wm off when stop clear", wm_f, 0);
      chk("R6 full off at depth 32", full, 0);
      stop = 1'b1; wm = 5'd3;
      set_mode(3'b010);
      put_run('h300000, 5);
      chk("R6 ring capped count", count, 3);
      chk("R6 ring capped head", head, 'h300002);
      chk("R6 ring wm", wm_f, 1);
      stop = 1'b0;

      // R7 ring then halt
      set_mode(3'b011);
      put_run('h400000, 34);
      chk("R7 ring before trig count", count, 32);
      chk("R7 ring before trig head", head, 'h400002);
      pulse_trig();
      put('h4AAAAA);
      chk("R7 halted count", count, 32);
      chk("R7 halted head", head, 'h400002);
      take();
      chk("R7 pop count", count, 31);
      chk("R11 pop clears ovr", ovr, 0);
      put('h4BBBBB);
      put('h4CCCCC);
      chk("R10 still halted count", count, 32);
      chk("R10 still halted head", head, 'h400003);
      chk("R10 still halted ovr", ovr, 1);

      // R8 bypass then ring
      set_mode(3'b100);
      put_run('h510000, 3);
      chk("R8 before trig count", count, 0);
      pulse_trig();
      put_run('h500000, 34);
      chk("R8 after trig count", count, 32);
      chk("R8 after trig head", head, 'h500002);
      // R10 re-entering a triggered mode needs a new trigger
      set_mode(3'b010);
      set_mode(3'b100);
      put('h520000);
      chk("R10 trigger forgotten", count, 0);

      // R9 bypass then halt
      set_mode(3'b111);
      put_run('h610000, 2);
      chk("R9 before trig count", count, 0);
      pulse_trig();
      put_run('h600000, 33);
      chk("R9 after trig count", count, 32);
      chk("R9 after trig head", head, 'h600000);
      chk("R9 ovr", ovr, 1);
      set_mode(3'b001);
      chk("R11 mode change count", count, 0);
      chk("R11 mode change ovr", ovr, 0);

      // R10 trigger ignored in plain ring mode
      set_mode(3'b010);
      pulse_trig();
      put_run('h700000, 34);
      chk("R10 ring unaffected count", count, 32);
      chk("R10 ring unaffected head", head, 'h700002);

      // R12 disable
      en = 1'b0;
      step();
      chk("R12 disable clears count", count, 0);
      chk("R12 disable empty", empty, 1);
      put('h777777);
      chk("R12 push ignored", count, 0);
      en = 1'b1;
      step();
      put('h123456);
      chk("R12 re-enabled count", count, 1);
      chk("R12 re-enabled head", head, 'h123456);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule